// File: doc/BRIEF.md
# Audio Interface Clock Generator

This block produces the serial bit clock and the left/right frame clock of an audio converter's serial port from the incoming master clock, for the case where the converter owns the interface timing. A three-bit mode input picks one of eight operating codes. Four codes make the block the clock master, each with its own master-clock-to-sample-rate ratio. Two codes make it a slave, and two codes are reserved.

In master operation the master clock is divided down to a bit clock of 64 times the sample rate, whatever the selected ratio. A frame clock at the sample rate is derived from the bit clock. In slave or reserved operation both clock outputs stay low. The active-low power-down input resets all timing. It is also the only point at which a new mode code is accepted: the code present during power-down stays in force until the next power-down.

Top module: `aud_clkgen`

## Requirements
- R1: The mode code `mode_sel` is decoded as follows. Codes 2, 3, 6 and 7 give `master_o`=1 and `bad_mode_o`=0. Codes 0 and 4 give both flags 0 (slave). Codes 1 and 5 give `bad_mode_o`=1 and `master_o`=0.
- R2: In master operation `bclk_o` has a period of N master-clock cycles, with N/2 cycles high and N/2 low. N is 4 for code 2, 8 for code 3, 6 for code 6 and 12 for code 7.
- R3: After `pwdn_n` is released, `bclk_o` first rises on the (N/2)-th rising master-clock edge that samples `pwdn_n` high.
- R4: `lrclk_o` toggles once every 32 bit-clock periods, so a frame is 64 bit clocks (N·64 master clocks). It starts low after power-down and only changes on the same master-clock edge at which `bclk_o` falls.
- R5: While `pwdn_n` is low, `bclk_o` and `lrclk_o` are low from the first master-clock edge that samples it low. The flags follow the mode pins one edge later.
- R6: In slave codes and reserved codes, `bclk_o` and `lrclk_o` stay low.
- R7: A change of `mode_sel` while `pwdn_n` is high affects neither the flags nor the clocks. The new code takes effect only after a power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| pwdn_n | input | 1 | Active-low power-down, synchronous to `mclk` |
| mode_sel | input | 3 | Operating code, captured during power-down |
| bclk_o | output | 1 | Serial bit clock, 64 times the sample rate |
| lrclk_o | output | 1 | Frame clock at the sample rate |
| master_o | output | 1 | High in master codes |
| bad_mode_o | output | 1 | High in reserved codes |

## Verification
The bench predicts the exact level of both clocks on every master-clock edge for all four ratios, across two full frames. A divider that miscounts the divide-by-6 case would show up as a skewed duty cycle or a wrong period. An off-by-one start would move the first rising bit-clock edge. A frame counter with the wrong length, or one clocked on the rising bit-clock edge, would flip the frame clock one bit early or late. The bench also flips the mode pins in mid-run, which a design that decodes the live pins would follow. It asserts power-down in mid-frame, where a design with stale counters would not return both clocks to low. Finally it selects each slave and reserved code, where any clock activity is an error.

// File: rtl/aud_clkgen.sv
module aud_clkgen #(
  parameter int BCLK_PER_FS = 64
) (
  input  logic       mclk,
  input  logic       pwdn_n,
  input  logic [2:0] mode_sel,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       master_o,
  output logic       bad_mode_o
);
  localparam int HALF_FRAME = BCLK_PER_FS / 2;
  localparam int BIT_W      = $clog2(HALF_FRAME);
  localparam int CNT_W      = 3;

  logic [2:0]       mode_q;
  logic [CNT_W-1:0] half, cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic             bclk_q, lr_q;

  always_comb begin
    case (mode_q)
      3'd2:    half = CNT_W'(2);
      3'd3:    half = CNT_W'(4);
      3'd6:    half = CNT_W'(3);
      3'd7:    half = CNT_W'(6);
      default: half = '0;
    endcase
  end

  assign master_o   = mode_q[1];
  assign bad_mode_o = (mode_q[1:0] == 2'b01);

  always_ff @(posedge mclk) begin
    if (!pwdn_n) begin
      mode_q <= mode_sel;
      cnt_q  <= '0;
      bit_q  <= '0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else if (master_o) begin
      if (cnt_q == half - CNT_W'(1)) begin
        cnt_q  <= '0;
        bclk_q <= ~bclk_q;
        if (bclk_q) begin
          if (bit_q == BIT_W'(HALF_FRAME - 1)) begin
            bit_q <= '0;
            lr_q  <= ~lr_q;
          end else begin
            bit_q <= bit_q + BIT_W'(1);
          end
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign bclk_o  = bclk_q;
  assign lrclk_o = lr_q;

  p_idle_low_r6: assert property (@(posedge mclk) disable iff (!pwdn_n)
    (!master_o || bad_mode_o) |-> (!bclk_o && !lrclk_o));

  p_lr_on_bfall_r4: assert property (@(posedge mclk) disable iff (!pwdn_n)
    (lrclk_o != $past(lrclk_o)) |-> $fell(bclk_o));

  p_mode_hold_r7: assert property (@(posedge mclk) disable iff (!pwdn_n)
    $past(pwdn_n) |-> ($stable(master_o) && $stable(bad_mode_o)));

  p_min_pulse_r2: assert property (@(posedge mclk) disable iff (!pwdn_n)
    $rose(bclk_o) |=> bclk_o);

  p_min_low_r2: assert property (@(posedge mclk) disable iff (!pwdn_n)
    ($fell(bclk_o) && $past(pwdn_n)) |=> !bclk_o);
endmodule

// File: tb/aud_clkgen_bench.sv
`timescale 1ns/1ps
module aud_clkgen_bench;
  logic       mclk = 1'b0;
  logic       pwdn_n = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic       bclk_o, lrclk_o, master_o, bad_mode_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic  b;
    logic  l;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 mclk = ~mclk;

  aud_clkgen u_aud_clkgen (
    .mclk(mclk), .pwdn_n(pwdn_n), .mode_sel(mode_sel),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o),
    .master_o(master_o), .bad_mode_o(bad_mode_o)
  );

  // monitor: compare one expected item per cycle
  always @(negedge mclk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (bclk_o !== e.b || lrclk_o !== e.l) begin
        fails++;
        $display("FAIL %s: bclk/lrclk actual %b/%b expected %b/%b", e.tag, bclk_o, lrclk_o, e.b, e.l);
      end
    end
  end

  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'd2: return 4;
      3'd3: return 8;
      3'd6: return 6;
      3'd7: return 12;
      default: return 0;
    endcase
  endfunction

  task automatic check_flags(input logic [2:0] c, input string tag);
    logic em, eb;
    em = (c == 3'd2 || c == 3'd3 || c == 3'd6 || c == 3'd7);
    eb = (c == 3'd1 || c == 3'd5);
    checks++;
    if (master_o !== em || bad_mode_o !== eb) begin
      fails++;
      $display("FAIL %s: master/bad actual %b/%b expected %b/%b", tag, master_o, bad_mode_o, em, eb);
    end
  endtask

  task automatic power_down(input logic [2:0] c);
    @(negedge mclk);
    pwdn_n   = 1'b0;
    mode_sel = c;
    for (int i = 0; i < 3; i++) begin
      @(posedge mclk);
      sb.push_back('{b: 1'b0, l: 1'b0, tag: "R5"});
    end
    @(negedge mclk);
    check_flags(c, "R1");
  endtask

  // driver: release power-down and push expected levels for each edge
  task automatic run_mode(input logic [2:0] c, input int ncyc, input logic [2:0] flip);
    int r, h;
    r = ratio_of(c);
    h = r / 2;
    power_down(c);
    pwdn_n = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge mclk);
      if (r == 0)
        sb.push_back('{b: 1'b0, l: 1'b0, tag: "R6"});
      else begin
        logic eb, el;
        eb = ((k / h) % 2) == 1;
        el = ((k / (32 * r)) % 2) == 1;
        if (el != (((k - 1) / (32 * r)) % 2 == 1))
          sb.push_back('{b: eb, l: el, tag: "R4"});
        else if (k <= h)
          sb.push_back('{b: eb, l: el, tag: "R3"});
        else if (k > ncyc / 2)
          sb.push_back('{b: eb, l: el, tag: "R7"});
        else
          sb.push_back('{b: eb, l: el, tag: "R2"});
      end
      if (k == ncyc / 2) begin
        @(negedge mclk);
        mode_sel = flip;
      end
    end
    @(negedge mclk);
    check_flags(c, "R7");
  endtask

  initial begin
    run_mode(3'd2, 2 * 64 * 4, 3'd7);
    run_mode(3'd3, 2 * 64 * 8, 3'd1);
    run_mode(3'd6, 2 * 64 * 6, 3'd0);
    run_mode(3'd7, 2 * 64 * 12, 3'd2);
    run_mode(3'd0, 40, 3'd3);
    run_mode(3'd4, 40, 3'd6);
    run_mode(3'd1, 40, 3'd2);
    run_mode(3'd5, 40, 3'd7);
    // power-down in mid-frame, then restart
    run_mode(3'd6, 500, 3'd6);
    power_down(3'd2);
    run_mode(3'd2, 300, 3'd2);
    power_down(3'd0);
    @(negedge mclk);
    repeat (2) @(negedge mclk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule